// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of an integrating converter that works in two timed phases. A start request first holds the external integrator in reset for a short, parameterised settling interval. It then routes the unknown input to the integrator for a fixed run-up of exactly 2^RES_BITS clock cycles. After that it switches the integrator to the opposite-polarity reference and counts clock cycles until the external zero-crossing comparator falls.

Because the run-up length is a power of two, the run-down count is the output code with no scaling, since input = reference × count / 2^RES_BITS. A comparator that never falls within the code range ends the run-down at the all-ones code and raises an overrange flag. The comparator is treated as asynchronous and passes through a synchroniser before its falling edge is detected.

The integrator, the switches and the comparator sit outside this block. The sequencer drives three mutually exclusive select lines, a busy level, a one-cycle completion pulse, and a result that holds until the next conversion completes.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is held and after it is released, every output is low, the result is 0 and the overrange flag is 0 until a start is accepted.
- R2: A start that is high at a clock edge while the sequencer is idle begins a conversion. From the next cycle, intClear is high for exactly ZERO_CYCLES cycles and busy is high.
- R3: Directly after the clear interval, selInput is high for exactly 2^RES_BITS consecutive cycles.
- R4: Directly after run-up, selRef is high from the first run-down cycle up to and including the cycle in which the run-down ends.
- R5: At most one of intClear, selInput and selRef is high in any cycle.
- R6: Number the run-down cycles from 0. If compIn is first sampled low in run-down cycle K, then K+2 is the run-down end cycle, the result is K+2 and the overrange flag is 0. The delay of 2 comes from the two-stage synchroniser and the edge detector. This holds when K+2 ≤ 2^RES_BITS−1.
- R7: If no falling edge is detected by run-down count 2^RES_BITS−1, run-down lasts 2^RES_BITS cycles, the result is all ones and the overrange flag is 1.
- R8: Comparator activity outside run-down has no effect. A low pulse during run-up does not change the result, and toggling compIn while idle leaves the result unchanged.
- R9: done is high for exactly one cycle. That cycle is the one after run-down ends, with the new result already valid, and busy is low in it. The block is idle in the following cycle.
- R10: result and overRange change only on the edge that raises done, and they are stable in every other cycle.
- R11: A start that arrives while a conversion is in progress is ignored. The run-up is not restarted or extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Conversion request, accepted when idle |
| compIn | input | 1 | Asynchronous zero-crossing comparator, high while the integrator is above zero |
| selInput | output | 1 | Connect the unknown input to the integrator (run-up) |
| selRef | output | 1 | Connect the opposite-polarity reference (run-down) |
| intClear | output | 1 | Short the integrator (clear interval) |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| overRange | output | 1 | Last result saturated |
| result | output | RES_BITS | Run-down count of the last conversion |

## Verification
The bench targets the edge of the code range. A fall at K = 2^RES_BITS−3 must give the all-ones code without overrange, and K = 2^RES_BITS−2 must give overrange. An off-by-one terminal compare or wrong synchroniser latency moves the code by one or flags the wrong case. It pulses compIn low during run-up and expects no early stop, so a detector not gated by phase would end the conversion at once. It also pulses start mid run-up: a sequencer that restarts would show a run-up longer than 2^RES_BITS. Every run checks that an overrange from an earlier conversion is cleared on the next normal result.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ZERO,
    ST_RUNUP,
    ST_RUNDOWN,
    ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic capture;
    logic capOvr;
  } dpCtrl_t;

  // flags from datapath to control
  typedef struct packed {
    logic zeroEnd;
    logic cntAtTop;
    logic compFall;
  } dpStat_t;

endpackage

// File: rtl/dsc_datapath.sv
module dsc_datapath
  import dsc_pkg::*;
#(
  parameter int RES_BITS    = 8,
  parameter int ZERO_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                compIn,
  input  dpCtrl_t             ctrl,
  output dpStat_t             stat,
  output logic [RES_BITS-1:0] result,
  output logic                overRange
);

  localparam int ZW    = $clog2(ZERO_CYCLES + 1);
  localparam int CNT_W = (RES_BITS > ZW) ? RES_BITS : ZW;
  localparam int unsigned TOP_CODE = (1 << RES_BITS) - 1;

  logic [CNT_W-1:0]       cntQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   compPrevQ;
  logic                   compSync;
  logic [RES_BITS-1:0]    resultQ;
  logic                   ovrQ;

  // shared phase counter
  always_ff @(posedge clk) begin
    if (!rstN)              cntQ <= '0;
    else if (ctrl.cntClear) cntQ <= '0;
    else if (ctrl.cntInc)   cntQ <= cntQ + 1'b1;
  end

  // comparator synchroniser, depth chosen by parameter
  generate
    if (SYNC_STAGES > 1) begin : gSyncChain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], compIn};
      end
    end else begin : gSyncOne
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= compIn;
      end
    end
  endgenerate

  assign compSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) compPrevQ <= 1'b0;
    else       compPrevQ <= compSync;
  end

  // result register, loaded only on capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      ovrQ    <= 1'b0;
    end else if (ctrl.capture) begin
      resultQ <= ctrl.capOvr ? '1 : cntQ[RES_BITS-1:0];
      ovrQ    <= ctrl.capOvr;
    end
  end

  assign stat.zeroEnd  = (cntQ == CNT_W'(ZERO_CYCLES - 1));
  assign stat.cntAtTop = (cntQ == CNT_W'(TOP_CODE));
  assign stat.compFall = compPrevQ & ~compSync;

  assign result    = resultQ;
  assign overRange = ovrQ;

  // R7: a saturated conversion always reports the all-ones code
  assert_ovr_saturates_R7: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> (&result));

  // R10: the captured value moves only on a capture strobe
  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> $stable(resultQ));

endmodule

// File: rtl/dsc_control.sv
module dsc_control
  import dsc_pkg::*;
#(
  parameter int RES_BITS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    selInput,
  output logic    selRef,
  output logic    intClear,
  output logic    busy,
  output logic    done
);

  localparam int unsigned T1 = 1 << RES_BITS;

  seqState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    ctrl   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startIn) begin
          stateD        = ST_ZERO;
          ctrl.cntClear = 1'b1;
        end
      end
      ST_ZERO: begin
        if (stat.zeroEnd) begin
          stateD        = ST_RUNUP;
          ctrl.cntClear = 1'b1;
        end else begin
          ctrl.cntInc = 1'b1;
        end
      end
      ST_RUNUP: begin
        if (stat.cntAtTop) begin
          stateD        = ST_RUNDOWN;
          ctrl.cntClear = 1'b1;
        end else begin
          ctrl.cntInc = 1'b1;
        end
      end
      ST_RUNDOWN: begin
        if (stat.compFall) begin
          stateD       = ST_DONE;
          ctrl.capture = 1'b1;
        end else if (stat.cntAtTop) begin
          stateD       = ST_DONE;
          ctrl.capture = 1'b1;
          ctrl.capOvr  = 1'b1;
        end else begin
          ctrl.cntInc = 1'b1;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign intClear = (stateQ == ST_ZERO);
  assign selInput = (stateQ == ST_RUNUP);
  assign selRef   = (stateQ == ST_RUNDOWN);
  assign busy     = intClear | selInput | selRef;
  assign done     = (stateQ == ST_DONE);

  // length monitors for the timed phases
  logic [RES_BITS:0] upLenQ;
  logic [RES_BITS:0] downLenQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upLenQ   <= '0;
      downLenQ <= '0;
    end else begin
      upLenQ   <= selInput ? upLenQ + 1'b1 : '0;
      downLenQ <= selRef ? downLenQ + 1'b1 : '0;
    end
  end

  // R5: switch selects never overlap
  assert_sel_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({intClear, selInput, selRef}));

  // R3: run-up always lasts the full power-of-two interval
  assert_runup_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selInput) |-> (upLenQ == (RES_BITS+1)'(T1)));

  // R7: run-down never exceeds the code range
  assert_rundown_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    selRef |-> (downLenQ < (RES_BITS+1)'(T1)));

  // R9: completion is a single-cycle pulse followed by idle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R11: an active conversion only leaves through done
  assert_no_abort_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsc_pkg::*;
#(
  parameter int RES_BITS    = 8,
  parameter int ZERO_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startIn,
  input  logic                compIn,
  output logic                selInput,
  output logic                selRef,
  output logic                intClear,
  output logic                busy,
  output logic                done,
  output logic                overRange,
  output logic [RES_BITS-1:0] result
);

  dpCtrl_t ctrlBus;
  dpStat_t statBus;

  dsc_control #(.RES_BITS(RES_BITS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .stat     (statBus),
    .ctrl     (ctrlBus),
    .selInput (selInput),
    .selRef   (selRef),
    .intClear (intClear),
    .busy     (busy),
    .done     (done)
  );

  dsc_datapath #(
    .RES_BITS   (RES_BITS),
    .ZERO_CYCLES(ZERO_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .compIn   (compIn),
    .ctrl     (ctrlBus),
    .stat     (statBus),
    .result   (result),
    .overRange(overRange)
  );

  // R10: port-level result and flag only move together with done
  assert_result_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    done || ($stable(result) && $stable(overRange)));

  // R9: busy and done never overlap
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

endmodule

// File: tb/tb_dual_slope_seq.sv
module tb_dual_slope_seq;

  localparam int CLK_PERIOD = 10;
  localparam int RES   = 8;
  localparam int ZCYC  = 4;
  localparam int SYNC  = 2;
  localparam int T1    = 1 << RES;
  localparam int MAXC  = T1 - 1;

  logic clk = 1'b0;
  logic rstN, startIn, compIn;
  logic selInput, selRef, intClear, busy, done, overRange;
  logic [RES-1:0] result;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_slope_seq #(.RES_BITS(RES), .ZERO_CYCLES(ZCYC), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .compIn(compIn),
    .selInput(selInput), .selRef(selRef), .intClear(intClear),
    .busy(busy), .done(done), .overRange(overRange), .result(result)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wrapUp;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic int expCode(input int k);
    return (k + SYNC <= MAXC) ? k + SYNC : MAXC;
  endfunction

  function automatic int expOvr(input int k);
    return (k + SYNC > MAXC) ? 1 : 0;
  endfunction

  // one conversion; k = run-down cycle in which compIn drops
  task automatic runConv(input int k, input bit pokeStart, input bit glitch);
    int zc = 0;
    int uc = 0;
    int rc = 0;
    bit overlap = 0;
    bit firstSeen = 0;
    bit gotDone = 0;
    int held;
    @(negedge clk);
    startIn = 1'b1;
    compIn  = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    while (!gotDone) begin
      if (!firstSeen) begin
        firstSeen = 1;
        check("R2", "clear active first cycle", int'(intClear), 1);
        check("R2", "busy after start", int'(busy), 1);
      end
      if (int'(intClear) + int'(selInput) + int'(selRef) > 1) overlap = 1;
      if (intClear) zc++;
      if (selInput) uc++;
      if (selRef) begin
        if (rc == k) compIn = 1'b0;
        rc++;
      end
      startIn = pokeStart && selInput && (uc == 10);
      if (glitch && selInput) compIn = !(uc >= 20 && uc < 23);
      if (done) begin
        gotDone = 1;
        check("R2", "clear length", zc, ZCYC);
        check("R3", "run-up length", uc, T1);
        if (pokeStart) check("R11", "run-up not restarted", uc, T1);
        check("R4", "run-down length", rc, expOvr(k) ? T1 : expCode(k) + 1);
        check("R5", "select overlap", int'(overlap), 0);
        if (expOvr(k)) begin
          check("R7", "saturated code", int'(result), MAXC);
          check("R7", "overrange flag", int'(overRange), 1);
        end else begin
          check(glitch ? "R8" : "R6", "code", int'(result), expCode(k));
          check("R6", "overrange clear", int'(overRange), 0);
        end
        check("R9", "busy in done cycle", int'(busy), 0);
      end else begin
        @(negedge clk);
      end
    end
    held = int'(result);
    @(negedge clk);
    check("R9", "done one cycle", int'(done), 0);
    check("R9", "idle after done", int'(busy), 0);
    for (int i = 0; i < 4; i++) begin
      compIn = ~compIn;
      @(negedge clk);
    end
    check("R10", "result held while idle", int'(result), held);
    compIn = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    wrapUp();
  end

  initial begin
    void'($urandom(32'd24681));
    rstN = 1'b0; startIn = 1'b0; compIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "select lines in reset", int'({intClear, selInput, selRef}), 0);
    check("R1", "busy/done in reset", int'({busy, done}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "result after reset", int'(result), 0);
    check("R1", "overrange after reset", int'(overRange), 0);
    check("R1", "idle after reset", int'({busy, done, intClear, selInput, selRef}), 0);

    runConv(5, 0, 0);
    runConv(0, 0, 0);
    runConv(MAXC - 2, 0, 0);   // lands exactly on top code, no overrange
    runConv(MAXC - 1, 0, 0);   // one cycle later: overrange
    runConv(100000, 0, 0);     // comparator never falls
    runConv(17, 0, 0);         // overrange must clear
    runConv(30, 1, 0);         // start during run-up
    runConv(40, 0, 1);         // comparator glitch during run-up

    for (int n = 0; n < 20; n++) begin
      int k;
      k = int'($urandom_range(0, MAXC + 4));
      runConv(k, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end
    wrapUp();
  end

endmodule